// File: doc/BRIEF.md
# Bus Lock Generator

This block drives the bus lock output that keeps other bus masters off the local bus while the core runs a chain of bus cycles that must not be split. It sees each bus cycle when that cycle enters its Ts state. At that point it gets a short descriptor from the core: the cycle kind, a flag saying the cycle belongs to a locked chain, a flag saying this cycle is the one before the final cycle, and a flag saying it is the final cycle of the chain. It also sees Ts and Tc phase strobes from the bus sequencer. The first Tc after a Ts is the first command clock of that cycle. Any further Tc clocks are wait states.

In a locked chain the lock comes on in the Ts clock of the first cycle. It stays on through every command clock, wait state and idle clock after that. It goes off after the first Tc of the cycle before the final one, whatever number of wait states follow, so the final cycle runs with the lock off. Interrupt-acknowledge cycles are locked one at a time. Each one has the lock on from its Ts through its first Tc and off from the next clock. The block does no instruction decoding. It only looks at the descriptor flags. Reset turns the lock off and clears all chain state.

Top module: `bus_lock_gen`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `bus_lock` is low unless that clock is a Ts. A Tc that has no Ts before it since reset does not raise `bus_lock`.
- R2: In a Ts clock whose descriptor is locked and not final, with a kind other than interrupt acknowledge (kind code 3'b000), `bus_lock` is high in that same clock.
- R3: Once raised for a chain, `bus_lock` stays high through the Tc clocks, wait-state Tc clocks and idle clocks of intermediate locked cycles.
- R4: In a cycle marked next-to-last (`cyc_penult`=1), `bus_lock` is high in its Ts and in its first Tc. It is low from the following clock on, for any number of wait states.
- R5: In a cycle marked final (`cyc_final`=1, kind other than 3'b000), `bus_lock` is low in every clock of that cycle.
- R6: A chain of one cycle, which has `cyc_locked`=1 and `cyc_final`=1 in its only cycle, never raises `bus_lock`.
- R7: Each interrupt-acknowledge cycle (kind 3'b000) has `bus_lock` high in its Ts and first Tc and low from the next clock, whatever its wait states. This holds for every such cycle in a row.
- R8: A Ts with `cyc_locked`=0 and a kind other than 3'b000 has `bus_lock` low for that whole cycle, and it drops any lock held before it.
- R9: `bus_lock` rises only in a Ts clock. Descriptor flags presented without `ph_ts` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_ts | input | 1 | Current clock is the Ts state of a new bus cycle; descriptor valid |
| ph_tc | input | 1 | Current clock is a Tc state (first command clock or a wait state) |
| cyc_kind | input | 3 | Cycle kind; 3'b000 = interrupt acknowledge |
| cyc_locked | input | 1 | Cycle belongs to a locked chain |
| cyc_penult | input | 1 | Cycle is the one before the final cycle of the chain |
| cyc_final | input | 1 | Cycle is the final cycle of the chain |
| bus_lock | output | 1 | Active-high bus lock |

## Verification
The bound checker tests on every clock the relations that depend only on the present Ts descriptor and on the clock before. These are: the lock comes on in Ts for starting cycles, it stays off for final and unlocked cycles, it rises only in Ts, it holds across idle clocks, and it is off right after reset. The early drop after the first Tc, the per-cycle release of interrupt-acknowledge locks with wait states, and single-cycle chains depend on where a cycle sits in a chain. Only the bench's directed scenarios show these, by checking each clock against a pattern written out from the requirements.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        CK_INTA  = 3'b000,
        CK_IORD  = 3'b001,
        CK_IOWR  = 3'b010,
        CK_HALT  = 3'b011,
        CK_CODE  = 3'b100,
        CK_MEMRD = 3'b101,
        CK_MEMWR = 3'b110,
        CK_NONE  = 3'b111
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      locked;
        logic      penult;
        logic      final_c;
    } cyc_desc_t;

    typedef struct packed {
        logic take_lock;
        logic drop_early;
    } lock_req_t;

    function automatic logic is_inta(input cyc_desc_t d);
        return d.kind == CK_INTA;
    endfunction

    function automatic lock_req_t decode_req(input cyc_desc_t d);
        lock_req_t r;
        if (is_inta(d)) begin
            r.take_lock  = 1'b1;
            r.drop_early = 1'b1;
        end else begin
            r.take_lock  = d.locked & ~d.final_c;
            r.drop_early = d.locked & d.penult;
        end
        return r;
    endfunction

endpackage

// File: rtl/lock_desc_dec.sv
module lock_desc_dec
    import lock_pkg::*;
(
    input  cyc_desc_t desc,
    output lock_req_t req
);
    always_comb begin
        req = decode_req(desc);
    end
endmodule

// File: rtl/lock_phase_trk.sv
module lock_phase_trk (
    input  logic clk,
    input  logic rst,
    input  logic ph_ts,
    input  logic ph_tc,
    output logic first_tc
);
    logic armed_q;

    always_comb begin
        first_tc = ph_tc & armed_q & ~ph_ts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (ph_ts) begin
            armed_q <= 1'b1;
        end else if (first_tc) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lock_hold_reg.sv
module lock_hold_reg
    import lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ph_ts,
    input  logic      first_tc,
    input  lock_req_t req,
    output logic      lock_q
);
    logic drop_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q      <= 1'b0;
            drop_pend_q <= 1'b0;
        end else if (ph_ts) begin
            lock_q      <= req.take_lock;
            drop_pend_q <= req.drop_early;
        end else if (first_tc && drop_pend_q) begin
            lock_q      <= 1'b0;
            drop_pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_lock_gen.sv
module bus_lock_gen
    import lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ph_ts,
    input  logic              ph_tc,
    input  logic [KIND_W-1:0] cyc_kind,
    input  logic              cyc_locked,
    input  logic              cyc_penult,
    input  logic              cyc_final,
    output logic              bus_lock
);
    cyc_desc_t desc;
    lock_req_t req;
    logic      first_tc;
    logic      lock_q;

    always_comb begin
        desc.kind    = cyc_kind_e'(cyc_kind);
        desc.locked  = cyc_locked;
        desc.penult  = cyc_penult;
        desc.final_c = cyc_final;
    end

    lock_desc_dec u_dec (
        .desc (desc),
        .req  (req)
    );

    lock_phase_trk u_trk (
        .clk      (clk),
        .rst      (rst),
        .ph_ts    (ph_ts),
        .ph_tc    (ph_tc),
        .first_tc (first_tc)
    );

    lock_hold_reg u_hold (
        .clk      (clk),
        .rst      (rst),
        .ph_ts    (ph_ts),
        .first_tc (first_tc),
        .req      (req),
        .lock_q   (lock_q)
    );

    // In Ts the new decision shows at once; otherwise the held state.
    always_comb begin
        bus_lock = ph_ts ? req.take_lock : lock_q;
    end
endmodule

// File: rtl/bus_lock_chk.sv
module bus_lock_chk
    import lock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ph_ts,
    input logic              ph_tc,
    input logic [KIND_W-1:0] cyc_kind,
    input logic              cyc_locked,
    input logic              cyc_final,
    input logic              bus_lock
);
    logic inta;
    assign inta = (cyc_kind == CK_INTA);

    a_r1_off_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_lock || ph_ts));

    a_r2_on_at_start: assert property (@(posedge clk) disable iff (rst)
        (ph_ts && !inta && cyc_locked && !cyc_final) |-> bus_lock);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && !ph_ts && !ph_tc) |=> (bus_lock || ph_ts));

    a_r5_final_off: assert property (@(posedge clk) disable iff (rst)
        (ph_ts && !inta && cyc_locked && cyc_final) |-> !bus_lock);

    a_r7_inta_on: assert property (@(posedge clk) disable iff (rst)
        (ph_ts && inta) |-> bus_lock);

    a_r8_unlocked_off: assert property (@(posedge clk) disable iff (rst)
        (ph_ts && !inta && !cyc_locked) |-> !bus_lock);

    a_r9_rise_in_ts: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_lock) |-> ph_ts);
endmodule

bind bus_lock_gen bus_lock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ph_ts      (ph_ts),
    .ph_tc      (ph_tc),
    .cyc_kind   (cyc_kind),
    .cyc_locked (cyc_locked),
    .cyc_final  (cyc_final),
    .bus_lock   (bus_lock)
);

// File: tb/sim_bus_lock_gen.sv
`timescale 1ns/1ps
module sim_bus_lock_gen;
    import lock_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ph_ts = 1'b0;
    logic              ph_tc = 1'b0;
    logic [KIND_W-1:0] cyc_kind = CK_NONE;
    logic              cyc_locked = 1'b0;
    logic              cyc_penult = 1'b0;
    logic              cyc_final = 1'b0;
    logic              bus_lock;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_lock_gen u0 (
        .clk(clk), .rst(rst), .ph_ts(ph_ts), .ph_tc(ph_tc),
        .cyc_kind(cyc_kind), .cyc_locked(cyc_locked),
        .cyc_penult(cyc_penult), .cyc_final(cyc_final),
        .bus_lock(bus_lock)
    );

    task automatic chk(input logic exp, input string tag);
        total++;
        if (bus_lock !== exp) begin
            bad++;
            $display("FAIL %s: bus_lock=%b expected=%b", tag, bus_lock, exp);
        end
    endtask

    task automatic idle_clk(input logic exp, input string tag);
        @(negedge clk);
        ph_ts = 1'b0; ph_tc = 1'b0;
        #1 chk(exp, tag);
    endtask

    // One bus cycle: Ts, first Tc, wait-state Tc clocks, idle clocks.
    task automatic bus_cycle(input cyc_kind_e k, input bit lk, input bit pen,
                             input bit fin, input int waits, input int idles,
                             input logic e_ts, input logic e_tc1,
                             input logic e_wt, input logic e_id,
                             input string tag);
        @(negedge clk);
        ph_ts = 1'b1; ph_tc = 1'b0;
        cyc_kind = k; cyc_locked = lk; cyc_penult = pen; cyc_final = fin;
        #1 chk(e_ts, {tag, " Ts"});
        @(negedge clk);
        ph_ts = 1'b0; ph_tc = 1'b1;
        cyc_kind = CK_NONE; cyc_locked = 1'b0; cyc_penult = 1'b0; cyc_final = 1'b0;
        #1 chk(e_tc1, {tag, " Tc1"});
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            ph_tc = 1'b1;
            #1 chk(e_wt, {tag, " wait"});
        end
        for (int i = 0; i < idles; i++) idle_clk(e_id, {tag, " idle"});
    endtask

    task automatic t_reset;
        chk(1'b0, "R1 in reset");
        @(negedge clk); rst = 1'b0;
        #1 chk(1'b0, "R1 after reset");
        @(negedge clk); ph_tc = 1'b1;
        #1 chk(1'b0, "R1 Tc without Ts");
        idle_clk(1'b0, "R1 idle");
        // reset in the middle of a chain
        bus_cycle(CK_MEMRD, 1, 0, 0, 0, 1, 1, 1, 1, 1, "R2 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 chk(1'b0, "R1 reset mid-chain");
    endtask

    task automatic t_chain3;
        bus_cycle(CK_MEMRD, 1, 0, 0, 1, 1, 1, 1, 1, 1, "R2 R3 first");
        bus_cycle(CK_MEMWR, 1, 1, 0, 2, 1, 1, 1, 0, 0, "R4 penult");
        bus_cycle(CK_MEMWR, 1, 0, 1, 1, 2, 0, 0, 0, 0, "R5 final");
    endtask

    task automatic t_chain_long;
        bus_cycle(CK_IORD, 1, 0, 0, 3, 2, 1, 1, 1, 1, "R3 mid a");
        bus_cycle(CK_IOWR, 1, 0, 0, 0, 0, 1, 1, 1, 1, "R3 mid b");
        bus_cycle(CK_IOWR, 1, 1, 0, 0, 1, 1, 1, 0, 0, "R4 penult no wait");
        bus_cycle(CK_IORD, 1, 0, 1, 0, 1, 0, 0, 0, 0, "R5 final");
    endtask

    task automatic t_single;
        bus_cycle(CK_MEMWR, 1, 0, 1, 2, 1, 0, 0, 0, 0, "R6 single");
    endtask

    task automatic t_inta;
        bus_cycle(CK_INTA, 1, 0, 0, 2, 1, 1, 1, 0, 0, "R7 inta 1");
        bus_cycle(CK_INTA, 1, 0, 0, 3, 2, 1, 1, 0, 0, "R7 inta 2");
    endtask

    task automatic t_unlocked;
        bus_cycle(CK_MEMRD, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R8 plain");
        bus_cycle(CK_CODE, 1, 0, 0, 0, 1, 1, 1, 1, 1, "R8 held");
        bus_cycle(CK_MEMRD, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R8 release");
    endtask

    task automatic t_norise;
        @(negedge clk);
        ph_ts = 1'b0; ph_tc = 1'b0;
        cyc_kind = CK_INTA; cyc_locked = 1'b1;
        #1 chk(1'b0, "R9 flags without Ts");
        @(negedge clk);
        cyc_kind = CK_MEMRD; ph_tc = 1'b1;
        #1 chk(1'b0, "R9 Tc with flags");
        idle_clk(1'b0, "R9 idle");
        cyc_kind = CK_NONE; cyc_locked = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset;
        t_chain3;
        t_chain_long;
        t_single;
        t_inta;
        t_unlocked;
        t_norise;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule